// File: doc/BRIEF.md
# Soft-Switch Memory Bank Controller

This block watches a processor's read accesses and decodes a sixteen-address soft-switch window at C080 to C08F hex. A read of a switch address rewrites a three-flag bank-control word. The first flag picks whether reads of the upper region come from ROM or from RAM. The second flag enables writes into that RAM. The third flag picks RAM bank 2 rather than bank 1 for the Dnnn region. The memory arrays and the processor core sit outside the block. They consume the flags and supply the strobes.

Half of the switch addresses act only when they are read twice in a row. The processor pulses an instruction-complete strobe that carries the effective address of the instruction that just finished. The block keeps that address. A guarded switch takes effect only when the address being read equals the kept address. So a single stray read cannot turn on RAM writes. A soft-switch read itself returns a zero data byte.

Top module: `bank_switch_ctrl`

## Requirements
- R1: After reset: `rom_read`=1, `ram_wr_en`=0, `bank2_sel`=1. The kept previous address is 0000 hex, so a first read of a guarded switch changes nothing.
- R2: A qualified read of C080 sets `rom_read`=0, `ram_wr_en`=0, `bank2_sel`=1 on the next rising clock edge.
- R3: A qualified read of C082 sets `rom_read`=1, `ram_wr_en`=0, `bank2_sel`=1 on a single read.
- R4: A qualified read of C088 clears all three flags.
- R5: A qualified read of C08A sets `rom_read`=1, `ram_wr_en`=0, `bank2_sel`=0.
- R6: A qualified read of C081 sets `rom_read`=1, `ram_wr_en`=1, `bank2_sel`=1, but only when the kept previous address equals the read address. Otherwise the flags are unchanged.
- R7: A qualified read of C083, with the same guard, sets `rom_read`=0, `ram_wr_en`=1, `bank2_sel`=1.
- R8: A qualified read of C089, with the same guard, sets `rom_read`=1, `ram_wr_en`=1, `bank2_sel`=0.
- R9: A qualified read of C08B, with the same guard, sets `rom_read`=0, `ram_wr_en`=1, `bank2_sel`=0. No other path ever raises `ram_wr_en`.
- R10: When `instr_done` is high at a clock edge, `instr_eff_addr` becomes the kept previous address. A read in that same cycle is compared against the value held before the edge.
- R11: `sw_hit` is high, in the same cycle, exactly when `rd_en`=1, `wr_en`=0 and `bus_addr` lies in C080 to C08F. `rd_data` is then 00.
- R12: Address bit 2 is ignored: C084 to C087 and C08C to C08F act as C080 to C083 and C088 to C08B. The guard still compares the full read address.
- R13: A read is qualified only when `rd_en`=1 and `wr_en`=0 and the address lies in the window. Write cycles, and reads outside the window, leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_addr | input | 16 | Processor bus address |
| rd_en | input | 1 | Read strobe for the current cycle |
| wr_en | input | 1 | Write strobe; when high, the cycle is a write |
| instr_done | input | 1 | Instruction-complete pulse |
| instr_eff_addr | input | 16 | Effective address of the completed instruction |
| rom_read | output | 1 | 1: upper-region reads come from ROM; 0: from RAM |
| ram_wr_en | output | 1 | 1: writes into upper-region RAM are allowed |
| bank2_sel | output | 1 | 1: bank 2 serves Dnnn; 0: bank 1 |
| sw_hit | output | 1 | Current cycle is a soft-switch read |
| rd_data | output | 8 | Data returned on a soft-switch read |

## Verification
The assertions take for granted that every input is at a known level at each rising edge. They also assume that `instr_eff_addr` carries meaning only in cycles where `instr_done` is high. The data-byte and hit checks assume that `rd_en` and `wr_en` are steady between edges. The stimulus meets these assumptions in three ways. It changes all inputs only on the falling edge. It holds `instr_eff_addr` at zero whenever `instr_done` is low. It drops every strobe to zero during reset, so nothing checked in the first cycle after reset sees an undriven value.

// File: rtl/bsw_pkg.sv
// Shared types and decode helpers for the soft-switch bank controller.
// Assumes the switch selector is {address bit 3, address bits 1:0}.
package bsw_pkg;

    typedef struct packed {
        logic rom_rd;   // 1: read from ROM
        logic wr_on;    // 1: RAM writes allowed
        logic bank2;    // 1: bank 2 selected
    } bank_cfg_t;

    localparam bank_cfg_t CFG_RESET = '{rom_rd: 1'b1, wr_on: 1'b0, bank2: 1'b1};

    // Target configuration for a three-bit switch selector.
    function automatic bank_cfg_t switch_target(input logic [2:0] sel);
        bank_cfg_t t;
        t.bank2  = ~sel[2];
        t.wr_on  = sel[0];
        t.rom_rd = sel[0] ^ sel[1];
        return t;
    endfunction

    // Odd selectors arm writes and so require a repeated read.
    function automatic logic needs_repeat(input logic [2:0] sel);
        return sel[0];
    endfunction

endpackage

// File: rtl/bsw_decode.sv
// Window decoder: flags addresses inside the switch window and extracts
// the switch selector, ignoring address bit 2.
// Assumes WIN_BASE is aligned to 2**WIN_BITS.
module bsw_decode #(
    parameter int ADDR_W = 16,
    parameter int WIN_BITS = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC080
) (
    input  logic [ADDR_W-1:0] addr_i,
    output logic              in_win_o,
    output logic [2:0]        sel_o
);
    localparam int TAG_W = ADDR_W - WIN_BITS;

    logic [TAG_W-1:0] tag_ref;
    assign tag_ref = WIN_BASE[ADDR_W-1:WIN_BITS];

    // Window match on upper address bits, selector from low bits.
    always_comb begin
        in_win_o = (addr_i[ADDR_W-1:WIN_BITS] == tag_ref);
        sel_o    = {addr_i[3], addr_i[1:0]};
    end
endmodule

// File: rtl/bsw_prev_addr.sv
// Holds the effective address of the last completed instruction.
// Assumes instr_done is a one-cycle pulse per instruction.
module bsw_prev_addr #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] RST_ADDR = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [ADDR_W-1:0] prev_o
);
    // Latch the finished instruction's effective address.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_o <= RST_ADDR;
        else if (load_i)
            prev_o <= addr_i;
    end
endmodule

// File: rtl/bsw_cfg_reg.sv
// Bank-configuration register: applies a decoded switch read, honouring
// the repeated-read guard on write-arming switches.
// Assumes take_i is already qualified by window hit and read-not-write.
module bsw_cfg_reg
    import bsw_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      take_i,
    input  logic [2:0] sel_i,
    input  logic      repeat_ok_i,
    output bank_cfg_t cfg_o
);
    logic apply;

    // Decide whether this read is allowed to change the configuration.
    always_comb begin
        apply = take_i && (!needs_repeat(sel_i) || repeat_ok_i);
    end

    // Update the configuration register.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cfg_o <= CFG_RESET;
        else if (apply)
            cfg_o <= switch_target(sel_i);
    end
endmodule

// File: rtl/bank_switch_ctrl.sv
// Soft-switch memory bank controller top. Decodes reads of the switch
// window, guards write-arming switches with a repeated-read check against
// the previous instruction's effective address, and drives the bank flags.
// Assumes inputs are synchronous to clk and strobes are single-cycle.
module bank_switch_ctrl
    import bsw_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int WIN_BITS = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC080
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic              instr_done,
    input  logic [ADDR_W-1:0] instr_eff_addr,
    output logic              rom_read,
    output logic              ram_wr_en,
    output logic              bank2_sel,
    output logic              sw_hit,
    output logic [DATA_W-1:0] rd_data
);
    logic              in_win;
    logic [2:0]        sel;
    logic [ADDR_W-1:0] prev_q;
    logic              repeat_ok;
    bank_cfg_t         cfg_q;

    bsw_decode #(
        .ADDR_W  (ADDR_W),
        .WIN_BITS(WIN_BITS),
        .WIN_BASE(WIN_BASE)
    ) u_dec (
        .addr_i  (bus_addr),
        .in_win_o(in_win),
        .sel_o   (sel)
    );

    bsw_prev_addr #(
        .ADDR_W  (ADDR_W),
        .RST_ADDR('0)
    ) u_prev (
        .clk   (clk),
        .rst_n (rst_n),
        .load_i(instr_done),
        .addr_i(instr_eff_addr),
        .prev_o(prev_q)
    );

    // Qualify the access and compare against the held address.
    always_comb begin
        sw_hit    = rd_en && !wr_en && in_win;
        repeat_ok = (prev_q == bus_addr);
    end

    bsw_cfg_reg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .take_i     (sw_hit),
        .sel_i      (sel),
        .repeat_ok_i(repeat_ok),
        .cfg_o      (cfg_q)
    );

    // Drive flag outputs and the zero read byte.
    always_comb begin
        rom_read  = cfg_q.rom_rd;
        ram_wr_en = cfg_q.wr_on;
        bank2_sel = cfg_q.bank2;
        rd_data   = '0;
    end
endmodule

// File: rtl/bsw_checker.sv
// Property checker for the soft-switch bank controller, bound to the top.
// Assumes known inputs at each rising edge.
module bsw_checker #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter int WIN_BITS = 4,
    parameter logic [ADDR_W-1:0] WIN_BASE = 16'hC080
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              rd_en,
    input logic              wr_en,
    input logic              instr_done,
    input logic [ADDR_W-1:0] instr_eff_addr,
    input logic              rom_read,
    input logic              ram_wr_en,
    input logic              bank2_sel,
    input logic              sw_hit,
    input logic [DATA_W-1:0] rd_data,
    input logic [ADDR_W-1:0] prev_addr
);
    logic win_rd;
    assign win_rd = rd_en && !wr_en &&
        (bus_addr[ADDR_W-1:WIN_BITS] == WIN_BASE[ADDR_W-1:WIN_BITS]);

    p_quiet_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
        !win_rd |=> $stable({rom_read, ram_wr_en, bank2_sel}));

    p_repeat_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rd && bus_addr[0] && prev_addr != bus_addr)
        |=> $stable({rom_read, ram_wr_en, bank2_sel}));

    p_single_bank_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rd && !bus_addr[0]) |=> (bank2_sel == !$past(bus_addr[3])));

    p_wr_needs_repeat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ram_wr_en) |-> ($past(bus_addr) == $past(prev_addr)));

    p_prev_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        instr_done |=> (prev_addr == $past(instr_eff_addr)));

    p_zero_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sw_hit |-> (rd_data == '0 && win_rd));
endmodule

bind bank_switch_ctrl bsw_checker #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .WIN_BITS(WIN_BITS),
    .WIN_BASE(WIN_BASE)
) u_bsw_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .rd_en         (rd_en),
    .wr_en         (wr_en),
    .instr_done    (instr_done),
    .instr_eff_addr(instr_eff_addr),
    .rom_read      (rom_read),
    .ram_wr_en     (ram_wr_en),
    .bank2_sel     (bank2_sel),
    .sw_hit        (sw_hit),
    .rd_data       (rd_data),
    .prev_addr     (prev_q)
);

// File: tb/test_bank_switch_ctrl.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected flags, the monitor compares.
module test_bank_switch_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic        instr_done = 1'b0;
    logic [15:0] instr_eff_addr = '0;
    logic        rom_read, ram_wr_en, bank2_sel, sw_hit;
    logic [7:0]  rd_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [2:0] flags;   // {rom, wr, bank2}
        string      tag;
    } exp_t;
    exp_t sb_q[$];

    logic        m_rom = 1'b1, m_wr = 1'b0, m_b2 = 1'b1;
    logic [15:0] m_prev = 16'h0000;

    always #2 clk = ~clk;   // 250 MHz

    bank_switch_ctrl i_bank_switch_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .rd_en(rd_en),
        .wr_en(wr_en), .instr_done(instr_done), .instr_eff_addr(instr_eff_addr),
        .rom_read(rom_read), .ram_wr_en(ram_wr_en), .bank2_sel(bank2_sel),
        .sw_hit(sw_hit), .rd_data(rd_data)
    );

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%s expected=%s", tag, act, exp);
        end
    endtask

    // Model from the requirements: apply one cycle of stimulus.
    task automatic model_step(input bit rd, input bit wr, input bit done,
                              input logic [15:0] a, input logic [15:0] eff);
        if (rd && !wr && a[15:4] == 12'hC08) begin
            case ({a[3], a[1:0]})
                3'b000: {m_rom, m_wr, m_b2} = 3'b001;
                3'b010: {m_rom, m_wr, m_b2} = 3'b101;
                3'b100: {m_rom, m_wr, m_b2} = 3'b000;
                3'b110: {m_rom, m_wr, m_b2} = 3'b100;
                3'b001: if (m_prev == a) {m_rom, m_wr, m_b2} = 3'b111;
                3'b011: if (m_prev == a) {m_rom, m_wr, m_b2} = 3'b011;
                3'b101: if (m_prev == a) {m_rom, m_wr, m_b2} = 3'b110;
                default: if (m_prev == a) {m_rom, m_wr, m_b2} = 3'b010;
            endcase
        end
        if (done) m_prev = eff;
    endtask

    // Driver: one cycle of stimulus, hit check, push expected flags.
    task automatic op(input bit rd, input bit wr, input bit done,
                      input logic [15:0] a, input logic [15:0] eff, input string tag);
        bit exp_hit;
        exp_t item;
        @(negedge clk);
        rd_en = rd; wr_en = wr; instr_done = done; bus_addr = a;
        instr_eff_addr = done ? eff : 16'h0000;
        #0.5;
        exp_hit = rd && !wr && (a[15:4] == 12'hC08);
        check(sw_hit == exp_hit, {"R11 hit ", tag}, $sformatf("%0b", sw_hit), $sformatf("%0b", exp_hit));
        if (exp_hit)
            check(rd_data == 8'h00, {"R11 data ", tag}, $sformatf("%02h", rd_data), "00");
        model_step(rd, wr, done, a, eff);
        item.flags = {m_rom, m_wr, m_b2};
        item.tag = tag;
        sb_q.push_back(item);
    endtask

    task automatic idle();
        @(negedge clk);
        rd_en = 0; wr_en = 0; instr_done = 0; bus_addr = '0; instr_eff_addr = '0;
    endtask

    // Monitor: compare flags one edge after each driven cycle.
    always @(posedge clk) begin
        #1;
        if (sb_q.size() > 0) begin
            exp_t it;
            it = sb_q.pop_front();
            check({rom_read, ram_wr_en, bank2_sel} == it.flags, it.tag,
                  $sformatf("%03b", {rom_read, ram_wr_en, bank2_sel}),
                  $sformatf("%03b", it.flags));
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #0.5;
        check({rom_read, ram_wr_en, bank2_sel} == 3'b101, "R1 reset flags",
              $sformatf("%03b", {rom_read, ram_wr_en, bank2_sel}), "101");

        op(1, 0, 0, 16'hC081, 0, "R1 R6 first C081 after reset ignored");
        op(1, 0, 0, 16'hC080, 0, "R2 C080");
        op(0, 0, 1, 16'h0000, 16'hC081, "R10 latch C081");
        op(1, 0, 0, 16'hC081, 0, "R6 repeated C081");
        op(1, 0, 0, 16'hC082, 0, "R3 C082");
        op(1, 0, 0, 16'hC083, 0, "R7 C083 without repeat");
        op(0, 0, 1, 16'h0000, 16'hC083, "R10 latch C083");
        op(1, 0, 0, 16'hC083, 0, "R7 repeated C083");
        op(1, 0, 0, 16'hC088, 0, "R4 C088");
        op(0, 0, 1, 16'h0000, 16'hC089, "R10 latch C089");
        op(1, 0, 0, 16'hC089, 0, "R8 repeated C089");
        op(1, 0, 0, 16'hC08A, 0, "R5 C08A");
        op(0, 0, 1, 16'h0000, 16'hC08B, "R10 latch C08B");
        op(1, 0, 0, 16'hC08B, 0, "R9 repeated C08B");
        op(1, 1, 0, 16'hC080, 0, "R13 write cycle to C080 ignored");
        op(0, 1, 0, 16'hC08A, 0, "R13 plain write ignored");
        op(1, 0, 0, 16'hC090, 0, "R13 read outside window");
        op(1, 0, 0, 16'hC07F, 0, "R13 read below window");
        op(1, 0, 0, 16'hC084, 0, "R12 alias C084 as C080");
        op(1, 0, 0, 16'hC08E, 0, "R12 alias C08E as C08A");
        op(1, 0, 0, 16'hC08C, 0, "R12 alias C08C as C088");
        op(1, 0, 1, 16'hC081, 16'hC081, "R10 same-cycle latch uses old address");
        op(1, 0, 0, 16'hC081, 0, "R10 R6 next read sees latched address");
        op(1, 0, 0, 16'hC088, 0, "R4 clear again");
        op(1, 0, 0, 16'hC085, 0, "R12 C085 guard compares full address");
        op(0, 0, 1, 16'h0000, 16'hC085, "R10 latch C085");
        op(1, 0, 0, 16'hC085, 0, "R12 repeated alias C085");
        op(1, 0, 1, 16'hC08F, 16'hC08F, "R12 C08F first read ignored");
        op(1, 0, 0, 16'hC08F, 0, "R12 R9 repeated alias C08F");
        idle();
        repeat (3) @(posedge clk);
        #1;
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule